// File: doc/BRIEF.md
# Memory Access Debug Checker

This block sits beside a processor's load/store unit and looks at every data access as it goes by. Each access arrives as a strobe with a 32-bit address and a store/load flag. First the address may be relocated into the current process's slot: the relocation field is ORed into the top address bits when those bits are all zero. The relocated address is then checked for misalignment and compared against a set of data watchpoints.

When alignment checking is on, a misaligned access raises a one-cycle abort pulse. The same edge captures a fixed fault-status code and the faulting address. Each watchpoint slot has its own 2-bit enable field that selects stores, loads, both or neither. In mask mode, slot 1's register becomes an inverse mask for slot 0, and slot 1 no longer matches on its own. A global debug-enable bit gates every watchpoint. On a hit, the block pulses a hit output and publishes a copy of the debug control word with a method-of-entry code placed in bits 4:2.

All results are registered and appear one clock after the access strobe. The configuration inputs are plain levels, held by registers elsewhere in the chip.

Top module: `mem_watch_checker`

## Requirements
- R1: After reset, `addr_valid`, `abort_pulse` and `bp_hit` are low, and `remap_addr`, `fault_status`, `fault_addr` and `dbg_status` are zero.
- R2: When `pid_hi` is nonzero and address bits 31:25 are all zero, `remap_addr` one cycle after the strobe equals the address with `pid_hi` ORed into bits 31:25.
- R3: When `pid_hi` is zero, or any of address bits 31:25 is set, `remap_addr` equals the incoming address unchanged.
- R4: With `align_en` high and either of address bits 1:0 of the relocated address set, `abort_pulse` is high for the cycle after the strobe. On that edge `fault_status` loads 32'h0000_0001 and `fault_addr` loads the relocated address.
- R5: With `align_en` low, or with address bits 1:0 both zero, there is no abort pulse, and `fault_status` and `fault_addr` keep their previous values.
- R6: Slot enable field encoding: 0 = slot off, 1 = stores only, 2 = loads and stores, 3 = loads only (`acc_store` high means store).
- R7: In normal mode (`bp_ctrl[4]` = 0), slot 0 uses `bp_ctrl[1:0]` and `bp_regs[31:0]`, and slot 1 uses `bp_ctrl[3:2]` and `bp_regs[63:32]`. A slot matches when address bits 31:2 equal its register's bits 31:2, so bits 1:0 are ignored.
- R8: In mask mode (`bp_ctrl[4]` = 1), slot 1 never matches on its own. Slot 0 matches when the address and `bp_regs[31:0]` agree on every bit where `bp_regs[63:32]` is 0, all 32 bits compared.
- R9: No watchpoint hit is reported while `dbg_ctrl[31]` is low, and `dbg_status` is left unchanged.
- R10: On a hit, `dbg_status` loads `dbg_ctrl` with bits 4:2 replaced by 3'b010. Without a hit, `dbg_status` holds its value.
- R11: Outputs follow the strobe by exactly one cycle. `abort_pulse` and `bp_hit` are low in any cycle that does not follow a strobe.
- R12: An access that is both misaligned and a watchpoint hit raises `abort_pulse` and `bp_hit` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 32 | Access address |
| acc_store | input | 1 | 1 = store, 0 = load |
| pid_hi | input | 7 | Process relocation field (upper 7 bits of the process-ID register) |
| align_en | input | 1 | Alignment check enable |
| bp_regs | input | 64 | Watchpoint registers, slot 0 in bits 31:0, slot 1 in bits 63:32 |
| bp_ctrl | input | 5 | Slot enable fields in bits 3:0, mask-mode flag in bit 4 |
| dbg_ctrl | input | 32 | Debug control word, bit 31 enables watchpoints |
| addr_valid | output | 1 | Registered copy of the strobe |
| remap_addr | output | 32 | Relocated address of the last access |
| abort_pulse | output | 1 | Alignment abort, one cycle |
| fault_status | output | 32 | Fault status, loaded on abort |
| fault_addr | output | 32 | Fault address, loaded on abort |
| bp_hit | output | 1 | Watchpoint hit, one cycle |
| dbg_status | output | 32 | Debug status carrying the method-of-entry code |

## Verification
The assertions take `acc_valid` to be a clean strobe, with `dbg_ctrl`, `align_en` and the relocation field sampled on the same edge as the address. They also rely on relocation being decided only by the strobe cycle's inputs. The bench changes configuration only at falling edges, together with or before a strobe, and holds it still across the capturing edge. Its random addresses are drawn close to the watchpoint registers and to the low, unrelocated region, so that hits, masked matches and relocations happen often.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
   // Slot enable encoding (R6)
   typedef enum logic [1:0] {
      SLOT_OFF    = 2'd0,
      SLOT_STORES = 2'd1,
      SLOT_BOTH   = 2'd2,
      SLOT_LOADS  = 2'd3
   } slot_mode_e;

   function automatic logic mode_allows(input logic [1:0] mode, input logic is_store);
      slot_mode_e m;
      m = slot_mode_e'(mode);
      case (m)
         SLOT_STORES: return is_store;
         SLOT_BOTH:   return 1'b1;
         SLOT_LOADS:  return !is_store;
         default:     return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/mwc_pid_remap.sv
module mwc_pid_remap #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PID_W  = 7
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PID_W-1:0]  pid_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int unsigned LOW_W = ADDR_W - PID_W;

   logic top_clear;

   always_comb begin
      top_clear = (addr_i[ADDR_W-1 -: PID_W] == '0);
      addr_o    = addr_i;
      if (top_clear && (pid_i != '0))
         addr_o = addr_i | {pid_i, {LOW_W{1'b0}}};
   end
endmodule

// File: rtl/mwc_align_chk.sv
module mwc_align_chk #(
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic                  en_i,
   input  logic [ALIGN_BITS-1:0] low_i,
   output logic                  misaligned_o
);
   always_comb misaligned_o = en_i && (low_i != '0);
endmodule

// File: rtl/mwc_bp_slot.sv
module mwc_bp_slot (
   input  logic       active_i,
   input  logic [1:0] mode_i,
   input  logic       store_i,
   input  logic       addr_eq_i,
   output logic       hit_o
);
   always_comb hit_o = active_i && addr_eq_i && mwc_pkg::mode_allows(mode_i, store_i);
endmodule

// File: rtl/mem_watch_checker.sv
module mem_watch_checker #(
   parameter int unsigned          ADDR_W      = 32,
   parameter int unsigned          PID_W       = 7,
   parameter int unsigned          ALIGN_BITS  = 2,
   parameter int unsigned          NUM_SLOTS   = 2,
   parameter int unsigned          DBG_EN_BIT  = 31,
   parameter int unsigned          MOE_LSB     = 2,
   parameter int unsigned          MOE_W       = 3,
   parameter logic [MOE_W-1:0]     MOE_DATA_BP = 3'd2,
   parameter logic [ADDR_W-1:0]    FSR_ALIGN   = 32'h0000_0001
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_valid,
   input  logic [ADDR_W-1:0]           acc_addr,
   input  logic                        acc_store,
   input  logic [PID_W-1:0]            pid_hi,
   input  logic                        align_en,
   input  logic [NUM_SLOTS*ADDR_W-1:0] bp_regs,
   input  logic [2*NUM_SLOTS:0]        bp_ctrl,
   input  logic [ADDR_W-1:0]           dbg_ctrl,
   output logic                        addr_valid,
   output logic [ADDR_W-1:0]           remap_addr,
   output logic                        abort_pulse,
   output logic [ADDR_W-1:0]           fault_status,
   output logic [ADDR_W-1:0]           fault_addr,
   output logic                        bp_hit,
   output logic [ADDR_W-1:0]           dbg_status
);
   localparam int unsigned MASK_MODE_BIT = 2 * NUM_SLOTS;
   localparam int unsigned CMP_W         = ADDR_W - ALIGN_BITS;

   generate
      if (PID_W >= ADDR_W) begin : g_bad_pid
         $error("PID_W must be smaller than ADDR_W");
      end
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("mask mode needs at least two slots");
      end
      if (MOE_LSB + MOE_W > ADDR_W) begin : g_bad_moe
         $error("method-of-entry field exceeds the status word");
      end
      if (DBG_EN_BIT >= ADDR_W) begin : g_bad_dbg
         $error("debug enable bit outside the control word");
      end
   endgenerate

   logic [ADDR_W-1:0]    reloc_addr;
   logic                 misaligned;
   logic                 mask_mode;
   logic [NUM_SLOTS-1:0] slot_hit;
   logic                 any_hit;
   logic [ADDR_W-1:0]    dbg_next;

   mwc_pid_remap #(.ADDR_W(ADDR_W), .PID_W(PID_W)) remap_i (
      .addr_i (acc_addr),
      .pid_i  (pid_hi),
      .addr_o (reloc_addr)
   );

   mwc_align_chk #(.ALIGN_BITS(ALIGN_BITS)) align_i (
      .en_i         (align_en),
      .low_i        (reloc_addr[ALIGN_BITS-1:0]),
      .misaligned_o (misaligned)
   );

   assign mask_mode = bp_ctrl[MASK_MODE_BIT];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [ADDR_W-1:0] reg_val;
      logic              coarse_eq;
      logic              eq;
      logic              active;

      assign reg_val   = bp_regs[s*ADDR_W +: ADDR_W];
      assign coarse_eq = (reloc_addr[ADDR_W-1 -: CMP_W] == reg_val[ADDR_W-1 -: CMP_W]);

      if (s == 0) begin : g_maskable
         logic [ADDR_W-1:0] inv_mask;
         logic              masked_eq;
         assign inv_mask  = bp_regs[ADDR_W +: ADDR_W];
         assign masked_eq = (((reloc_addr ^ reg_val) & ~inv_mask) == '0);
         assign eq        = mask_mode ? masked_eq : coarse_eq;
         assign active    = 1'b1;
      end else begin : g_plain
         assign eq     = coarse_eq;
         assign active = !mask_mode;
      end

      mwc_bp_slot slot_i (
         .active_i  (active),
         .mode_i    (bp_ctrl[2*s +: 2]),
         .store_i   (acc_store),
         .addr_eq_i (eq),
         .hit_o     (slot_hit[s])
      );
   end

   always_comb begin
      any_hit  = dbg_ctrl[DBG_EN_BIT] && (slot_hit != '0);
      dbg_next = dbg_ctrl;
      dbg_next[MOE_LSB +: MOE_W] = MOE_DATA_BP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_valid   <= 1'b0;
         remap_addr   <= '0;
         abort_pulse  <= 1'b0;
         fault_status <= '0;
         fault_addr   <= '0;
         bp_hit       <= 1'b0;
         dbg_status   <= '0;
      end else begin
         addr_valid  <= acc_valid;
         abort_pulse <= acc_valid && misaligned;
         bp_hit      <= acc_valid && any_hit;
         if (acc_valid) begin
            remap_addr <= reloc_addr;
            if (misaligned) begin
               fault_status <= FSR_ALIGN;
               fault_addr   <= reloc_addr;
            end
            if (any_hit)
               dbg_status <= dbg_next;
         end
      end
   end
endmodule

// File: rtl/mwc_checker.sv
module mwc_checker #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       PID_W       = 7,
   parameter int unsigned       ALIGN_BITS  = 2,
   parameter int unsigned       MOE_W       = 3,
   parameter logic [MOE_W-1:0]  MOE_DATA_BP = 3'd2,
   parameter logic [ADDR_W-1:0] FSR_ALIGN   = 32'h0000_0001
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_valid,
   input logic [PID_W-1:0]      addr_top,
   input logic [PID_W-1:0]      pid_hi,
   input logic                  align_en,
   input logic                  dbg_on,
   input logic                  abort_pulse,
   input logic                  bp_hit,
   input logic [ADDR_W-1:0]     fault_status,
   input logic [ALIGN_BITS-1:0] fault_low,
   input logic [PID_W-1:0]      remap_top,
   input logic [MOE_W-1:0]      moe_field
);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !(abort_pulse || bp_hit));

   // R9
   dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> $past(dbg_on));

   // R10
   moe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> moe_field == MOE_DATA_BP);

   // R4
   abort_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (fault_low != '0) && (fault_status == FSR_ALIGN));

   // R5
   no_align_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !align_en) |=> !abort_pulse);

   // R2
   pid_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && pid_hi != '0 && addr_top == '0) |=> remap_top == $past(pid_hi));
endmodule

bind mem_watch_checker mwc_checker #(
   .ADDR_W(ADDR_W), .PID_W(PID_W), .ALIGN_BITS(ALIGN_BITS),
   .MOE_W(MOE_W), .MOE_DATA_BP(MOE_DATA_BP), .FSR_ALIGN(FSR_ALIGN)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .addr_top     (acc_addr[ADDR_W-1 -: PID_W]),
   .pid_hi       (pid_hi),
   .align_en     (align_en),
   .dbg_on       (dbg_ctrl[DBG_EN_BIT]),
   .abort_pulse  (abort_pulse),
   .bp_hit       (bp_hit),
   .fault_status (fault_status),
   .fault_low    (fault_addr[ALIGN_BITS-1:0]),
   .remap_top    (remap_addr[ADDR_W-1 -: PID_W]),
   .moe_field    (dbg_status[MOE_LSB +: MOE_W])
);

// File: tb/mem_watch_checker_tb_top.sv
`timescale 1ns/1ps
module mem_watch_checker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_store = 1'b0;
   logic [6:0]  pid_hi = '0;
   logic        align_en = 1'b0;
   logic [31:0] bp0 = '0, bp1 = '0;
   logic [4:0]  bp_ctrl = '0;
   logic [31:0] dbg_ctrl = '0;
   logic        addr_valid, abort_pulse, bp_hit;
   logic [31:0] remap_addr, fault_status, fault_addr, dbg_status;

   int tests = 0;
   int fails = 0;

   // expected model state
   logic [31:0] e_remap = '0, e_fsr = '0, e_far = '0, e_dbg = '0;

   always #4 clk = ~clk;

   mem_watch_checker dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_store(acc_store), .pid_hi(pid_hi), .align_en(align_en),
      .bp_regs({bp1, bp0}), .bp_ctrl(bp_ctrl), .dbg_ctrl(dbg_ctrl),
      .addr_valid(addr_valid), .remap_addr(remap_addr), .abort_pulse(abort_pulse),
      .fault_status(fault_status), .fault_addr(fault_addr), .bp_hit(bp_hit),
      .dbg_status(dbg_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic allows(input logic [1:0] m, input logic st);
      return (m != 2'd0) && (st ? (m != 2'd3) : (m != 2'd1));
   endfunction

   function automatic logic [31:0] relocate(input logic [31:0] a, input logic [6:0] p);
      if (p != 0 && a[31:25] == 7'd0) return a | {p, 25'd0};
      return a;
   endfunction

   function automatic logic hit_of(input logic [31:0] a, input logic st);
      logic h;
      if (!dbg_ctrl[31]) return 1'b0;
      if (bp_ctrl[4])
         h = allows(bp_ctrl[1:0], st) && (((a ^ bp0) & ~bp1) == 32'd0);
      else
         h = (allows(bp_ctrl[1:0], st) && a[31:2] == bp0[31:2]) ||
             (allows(bp_ctrl[3:2], st) && a[31:2] == bp1[31:2]);
      return h;
   endfunction

   // one access: drive on a falling edge, check on the next falling edge
   task automatic access(input logic [31:0] a, input logic st, input string tag);
      logic [31:0] r;
      logic        ab, h;
      @(negedge clk);
      acc_addr  = a;
      acc_store = st;
      acc_valid = 1'b1;
      r  = relocate(a, pid_hi);
      ab = align_en && (r[1:0] != 2'd0);
      h  = hit_of(r, st);
      e_remap = r;
      if (ab) begin e_fsr = 32'h1; e_far = r; end
      if (h) begin e_dbg = dbg_ctrl; e_dbg[4:2] = 3'b010; end
      @(negedge clk);
      acc_valid = 1'b0;
      chk({tag, " R11 valid"}, {31'd0, addr_valid}, 32'd1);
      chk({tag, " R2/R3 remap"}, remap_addr, e_remap);
      chk({tag, " R4/R5 abort"}, {31'd0, abort_pulse}, {31'd0, ab});
      chk({tag, " R4/R5 fsr"}, fault_status, e_fsr);
      chk({tag, " R4/R5 far"}, fault_addr, e_far);
      chk({tag, " R6/R7/R8 hit"}, {31'd0, bp_hit}, {31'd0, h});
      chk({tag, " R10 status"}, dbg_status, e_dbg);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", {31'd0, addr_valid}, 32'd0);
      chk("R1 abort", {31'd0, abort_pulse}, 32'd0);
      chk("R1 hit", {31'd0, bp_hit}, 32'd0);
      chk("R1 remap", remap_addr, 32'd0);
      chk("R1 fsr", fault_status, 32'd0);
      chk("R1 status", dbg_status, 32'd0);
      rst_n = 1'b1;

      // R2 relocation of a low address
      pid_hi = 7'h15;
      access(32'h0000_1000, 1'b0, "R2");
      chk("R2 directed", remap_addr, 32'h2A00_1000);
      // R3 no relocation: top bits set, or zero field
      access(32'h0400_1000, 1'b0, "R3 top");
      chk("R3 directed", remap_addr, 32'h0400_1000);
      pid_hi = 7'h0;
      access(32'h0000_2000, 1'b0, "R3 zero");

      // R4 alignment abort then R5 disabled check
      align_en = 1'b1;
      access(32'h0000_1003, 1'b1, "R4");
      chk("R4 far", fault_addr, 32'h0000_1003);
      align_en = 1'b0;
      access(32'h0000_5001, 1'b1, "R5 off");
      chk("R5 far kept", fault_addr, 32'h0000_1003);
      align_en = 1'b1;
      access(32'h0000_6000, 1'b0, "R5 aligned");

      // R6 encodings on slot 0, loads and stores
      align_en = 1'b0;
      dbg_ctrl = 32'h8000_00FF;
      bp0 = 32'h0000_2000;
      bp1 = 32'h0000_3000;
      for (int m = 0; m < 4; m++) begin
         bp_ctrl = {3'b000, m[1:0]};
         access(32'h0000_2000, 1'b0, "R6 load");
         access(32'h0000_2000, 1'b1, "R6 store");
      end
      chk("R10 directed", dbg_status, 32'h8000_00EB);

      // R7 slot 1 field, low bits ignored
      bp_ctrl = 5'b0_10_00;
      access(32'h0000_3003, 1'b0, "R7 slot1");
      access(32'h0000_3004, 1'b0, "R7 miss");

      // R8 mask mode: slot 1 silenced, masked compare on slot 0
      bp_ctrl = 5'b1_10_10;
      bp1 = 32'h0000_00F0;
      access(32'h0000_20A0, 1'b1, "R8 masked");
      access(32'h0000_2001, 1'b1, "R8 exact");
      access(32'h0000_00F0, 1'b0, "R8 slot1");

      // R9 debug disabled, status must hold
      dbg_ctrl = 32'h0000_0000;
      bp_ctrl = 5'b0_10_10;
      access(32'h0000_2000, 1'b0, "R9");
      chk("R9 held", dbg_status, 32'h8000_00EB);

      // R12 abort and hit together
      dbg_ctrl = 32'h8000_0000;
      align_en = 1'b1;
      access(32'h0000_2002, 1'b1, "R12");
      chk("R12 both", {30'd0, abort_pulse, bp_hit}, 32'd3);
      // R11 idle cycle is quiet
      @(negedge clk);
      chk("R11 idle", {30'd0, abort_pulse, bp_hit}, 32'd0);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         int          pick;
         pid_hi   = ($urandom % 3 == 0) ? 7'd0 : 7'($urandom);
         align_en = 1'($urandom);
         bp0      = $urandom;
         bp_ctrl  = 5'($urandom);
         bp1      = bp_ctrl[4] ? ($urandom & $urandom & $urandom) : $urandom;
         dbg_ctrl = ($urandom % 4 == 0) ? ($urandom & 32'h7FFF_FFFF) : ($urandom | 32'h8000_0000);
         pick = int'($urandom % 4);
         case (pick)
            0: a = relocate(bp0, pid_hi) ^ {30'd0, 2'($urandom)};
            1: a = relocate(bp1, pid_hi) ^ {30'd0, 2'($urandom)};
            2: a = $urandom & 32'h01FF_FFFF;
            default: a = $urandom;
         endcase
         access(a, 1'($urandom), "RND");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule